// File: doc/BRIEF.md
# Mirrored Memory Channel Controller

This block stands between one memory request port and two memory copies that sit on separate power domains: copy A (the first pair of memory cards) and copy B (the second pair). With mirroring switched off, each copy holds its own half of the address space. With mirroring switched on, the usable space halves and every write lands in both copies. Each read goes to the copy that the scrubber has charged with fewer errors.

When the scrubber or system logic declares a copy unusable, the controller fails over. All traffic then goes to the survivor and a fault flag is raised. The survivor keeps serving until the failed copy is replaced. After replacement, a hardware sweep walks every word address. It reads the survivor and writes the new copy while yielding the ports to host traffic. At the end of the sweep the controller returns to the fully mirrored state and the fault flag drops. DRAM timing, ECC and the scrubber itself lie outside this block. Each copy port is a simple synchronous RAM port with one cycle of read latency.

Top module: `mirror_mem_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (mirrored), fault_o is 0, rsp_valid is 0 and mirroring is off. The enable input is registered, so mirroring takes effect from the cycle after cfg_mirror_en is sampled high.
- R2: With mirroring off, address bit AW-1 selects the copy (0 for A, 1 for B). The lower AW-1 bits give the word address. Only the selected copy is accessed.
- R3: With mirroring on and mode_o 0, a write stores its data at word address req_addr[AW-2:0] in both copies. Address bit AW-1 is ignored.
- R4: With mirroring on and mode_o 0, a read is served by copy B only when scrub_err_b is strictly less than scrub_err_a. Otherwise, including equal counts, copy A serves it.
- R5: With mirroring on and mode_o 0, copy_dead_a moves mode_o to 1 on the next cycle and copy_dead_b moves it to 2; copy_dead_a wins if both are set. fault_o is 1 in either degraded mode. In mode 1 only copy B is accessed, and in mode 2 only copy A is accessed, whatever the error counts.
- R6: A degraded mode is left only through the replacement strobe of the failed copy. The strobe of the other copy has no effect.
- R7: The replacement strobe of the failed copy moves mode_o to 3 (rebuild) on the next cycle. The rebuild copies every word from the survivor to the new copy and then returns mode_o to 0 with fault_o 0.
- R8: During rebuild, a host read of a word the sweep has not yet written is served by the survivor. A read of a word already written is steered as in R4.
- R9: During rebuild, a host write goes to both copies, and the sweep stalls in any cycle that carries a host request. A host write to the word being copied is never overwritten by stale copy-back data.
- R10: rsp_valid is high exactly in the cycle after a read request, and rsp_rdata then carries the word from the copy that served it.
- R11: Dropping cfg_mirror_en returns mode_o to 0 and fault_o to 0 on the next cycle. While mirroring is off, the dead strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mirror_en | input | 1 | Mirroring enable (configuration level) |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Host address |
| req_wdata | input | DW | Host write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| scrub_err_a | input | CW | Scrubber error count of copy A |
| scrub_err_b | input | CW | Scrubber error count of copy B |
| copy_dead_a | input | 1 | Copy A declared unusable |
| copy_dead_b | input | 1 | Copy B declared unusable |
| copy_replaced_a | input | 1 | Copy A has been replaced |
| copy_replaced_b | input | 1 | Copy B has been replaced |
| mem_a_en | output | 1 | Copy A access enable |
| mem_a_we | output | 1 | Copy A write enable |
| mem_a_addr | output | AW-1 | Copy A word address |
| mem_a_wdata | output | DW | Copy A write data |
| mem_a_rdata | input | DW | Copy A read data, one cycle after the read |
| mem_b_en | output | 1 | Copy B access enable |
| mem_b_we | output | 1 | Copy B write enable |
| mem_b_addr | output | AW-1 | Copy B word address |
| mem_b_wdata | output | DW | Copy B write data |
| mem_b_rdata | input | DW | Copy B read data, one cycle after the read |
| mode_o | output | 2 | 0 mirrored, 1 A failed, 2 B failed, 3 rebuild |
| fault_o | output | 1 | Raised from failover until rebuild completes |

## Verification
The bench builds the block with AW=6, DW=16 and CW=4. Each copy then has 32 words, so a full rebuild sweep, including the wrap of its pointer at the last word, completes in a few hundred cycles under random host load. The 4-bit error counts make equal counts, and counts of zero and fifteen, frequent under random stimulus. The small depth also lets the bench preload both copies with distinct data while mirroring is off, which exposes at the read port which copy served each read.

// File: rtl/mm_pkg.sv
// Shared types for the mirrored memory channel controller.
package mm_pkg;

    // Failover modes; the encoding is visible on mode_o.
    typedef enum logic [1:0] {
        ST_MIRRORED = 2'd0,
        ST_DEG_A    = 2'd1,
        ST_DEG_B    = 2'd2,
        ST_REBUILD  = 2'd3
    } mm_state_e;

    // Copy-back sequencer phases.
    typedef enum logic [1:0] {
        PH_READ    = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_WRITE   = 2'd2
    } mm_phase_e;

endpackage

// File: rtl/mm_failover_fsm.sv
// Failover state machine.
// Tracks whether both copies are live, which copy has failed, and whether a
// rebuild is running. Assumes the dead and replaced inputs are single-cycle
// strobes from system logic. Clearing the enable forces the mirrored state.
module mm_failover_fsm
    import mm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en_i,
    input  logic      mirror_on_i,
    input  logic      dead_a_i,
    input  logic      dead_b_i,
    input  logic      repl_a_i,
    input  logic      repl_b_i,
    input  logic      rb_done_i,
    output mm_state_e state_o,
    output logic      rb_to_b_o
);

    mm_state_e state_q, state_nx;
    logic      to_b_q;

    // Next-state selection from strobes and sweep completion.
    always_comb begin
        state_nx = state_q;
        if (!cfg_en_i) begin
            state_nx = ST_MIRRORED;
        end else begin
            case (state_q)
                ST_MIRRORED: begin
                    if (mirror_on_i && dead_a_i)      state_nx = ST_DEG_A;
                    else if (mirror_on_i && dead_b_i) state_nx = ST_DEG_B;
                end
                ST_DEG_A:   if (repl_a_i)  state_nx = ST_REBUILD;
                ST_DEG_B:   if (repl_b_i)  state_nx = ST_REBUILD;
                ST_REBUILD: if (rb_done_i) state_nx = ST_MIRRORED;
                default:    state_nx = ST_MIRRORED;
            endcase
        end
    end

    // State register and rebuild-direction latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MIRRORED;
            to_b_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_DEG_B && state_nx == ST_REBUILD) to_b_q <= 1'b1;
            if (state_q == ST_DEG_A && state_nx == ST_REBUILD) to_b_q <= 1'b0;
        end
    end

    assign state_o   = state_q;
    assign rb_to_b_o = to_b_q;

endmodule

// File: rtl/mm_rebuild_seq.sv
// Copy-back address sequencer.
// Walks word addresses from zero to the last word. For each word it reads the
// survivor, captures the data, then writes the new copy. It issues nothing in
// a cycle that carries a host request. A host write to the word in flight
// replaces the captured data. Assumes one cycle of read latency on the
// source copy.
module mm_rebuild_seq
    import mm_pkg::*;
#(
    parameter int IW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          host_busy_i,
    input  logic          host_wr_i,
    input  logic [IW-1:0] host_idx_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic [DW-1:0] src_rdata_i,
    output logic          rd_en_o,
    output logic          wr_en_o,
    output logic [IW-1:0] ptr_o,
    output logic [DW-1:0] wdata_o,
    output logic          done_o
);

    localparam logic [IW-1:0] LAST_IDX = {IW{1'b1}};

    logic [IW-1:0] ptr_q;
    logic [DW-1:0] hold_q;
    mm_phase_e     phase_q;
    logic          hit;

    // Issue strobes: the host always has priority on the copy ports.
    always_comb begin
        hit     = host_wr_i && (host_idx_i == ptr_q);
        rd_en_o = active_i && (phase_q == PH_READ)  && !host_busy_i;
        wr_en_o = active_i && (phase_q == PH_WRITE) && !host_busy_i;
        done_o  = wr_en_o && (ptr_q == LAST_IDX);
    end

    // Pointer, phase and captured-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            phase_q <= PH_READ;
            hold_q  <= '0;
        end else if (!active_i) begin
            ptr_q   <= '0;
            phase_q <= PH_READ;
        end else begin
            case (phase_q)
                PH_READ: if (rd_en_o) phase_q <= PH_CAPTURE;
                PH_CAPTURE: begin
                    hold_q  <= hit ? host_wdata_i : src_rdata_i;
                    phase_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    if (wr_en_o) begin
                        ptr_q   <= ptr_q + 1'b1;
                        phase_q <= PH_READ;
                    end else if (hit) begin
                        hold_q <= host_wdata_i;
                    end
                end
                default: phase_q <= PH_READ;
            endcase
        end
    end

    assign ptr_o   = ptr_q;
    assign wdata_o = hold_q;

endmodule

// File: rtl/mirror_mem_ctrl.sv
// Mirrored memory channel controller (top).
// Routes host requests to two memory copies, steers reads by scrub error
// counts, fails over to a survivor and runs a copy-back rebuild. Assumes both
// copy ports are synchronous RAMs with one cycle of read latency and that the
// scrubber counts are stable while a read is presented.
module mirror_mem_ctrl
    import mm_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_mirror_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic [CW-1:0] scrub_err_a,
    input  logic [CW-1:0] scrub_err_b,
    input  logic          copy_dead_a,
    input  logic          copy_dead_b,
    input  logic          copy_replaced_a,
    input  logic          copy_replaced_b,
    output logic          mem_a_en,
    output logic          mem_a_we,
    output logic [AW-2:0] mem_a_addr,
    output logic [DW-1:0] mem_a_wdata,
    input  logic [DW-1:0] mem_a_rdata,
    output logic          mem_b_en,
    output logic          mem_b_we,
    output logic [AW-2:0] mem_b_addr,
    output logic [DW-1:0] mem_b_wdata,
    input  logic [DW-1:0] mem_b_rdata,
    output logic [1:0]    mode_o,
    output logic          fault_o
);

    localparam int IW = AW - 1;

    mm_state_e     state;
    logic          mirror_q;
    logic          rb_to_b;
    logic          rb_rd, rb_wr, rb_done;
    logic [IW-1:0] rb_ptr;
    logic [DW-1:0] rb_wdata;
    logic [IW-1:0] idx;
    logic          steer_b, sel_b, host_a, host_b;
    logic          rsp_q, sel_q;

    assign idx     = req_addr[IW-1:0];
    assign steer_b = (scrub_err_b < scrub_err_a);

    // Registered mirroring enable; off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mirror_q <= 1'b0;
        else        mirror_q <= cfg_mirror_en;
    end

    mm_failover_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en_i    (cfg_mirror_en),
        .mirror_on_i (mirror_q),
        .dead_a_i    (copy_dead_a),
        .dead_b_i    (copy_dead_b),
        .repl_a_i    (copy_replaced_a),
        .repl_b_i    (copy_replaced_b),
        .rb_done_i   (rb_done),
        .state_o     (state),
        .rb_to_b_o   (rb_to_b)
    );

    mm_rebuild_seq #(.IW(IW), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (state == ST_REBUILD),
        .host_busy_i  (req_valid),
        .host_wr_i    (req_valid && req_write),
        .host_idx_i   (idx),
        .host_wdata_i (req_wdata),
        .src_rdata_i  (rb_to_b ? mem_a_rdata : mem_b_rdata),
        .rd_en_o      (rb_rd),
        .wr_en_o      (rb_wr),
        .ptr_o        (rb_ptr),
        .wdata_o      (rb_wdata),
        .done_o       (rb_done)
    );

    // Host routing: which copies a request touches and which copy serves a read.
    always_comb begin
        sel_b  = 1'b0;
        host_a = 1'b0;
        host_b = 1'b0;
        if (!mirror_q) begin
            sel_b  = req_addr[AW-1];
            host_a = req_valid && !req_addr[AW-1];
            host_b = req_valid &&  req_addr[AW-1];
        end else begin
            case (state)
                ST_DEG_A: begin sel_b = 1'b1; host_b = req_valid; end
                ST_DEG_B: begin sel_b = 1'b0; host_a = req_valid; end
                ST_REBUILD: begin
                    sel_b  = (idx < rb_ptr) ? steer_b : !rb_to_b;
                    host_a = req_valid && (req_write || !sel_b);
                    host_b = req_valid && (req_write ||  sel_b);
                end
                default: begin
                    sel_b  = steer_b;
                    host_a = req_valid && (req_write || !sel_b);
                    host_b = req_valid && (req_write ||  sel_b);
                end
            endcase
        end
    end

    // Copy port muxes: host first, otherwise copy-back traffic.
    always_comb begin
        mem_a_en    = host_a || (rb_rd && rb_to_b) || (rb_wr && !rb_to_b);
        mem_a_we    = host_a ? req_write : (rb_wr && !rb_to_b);
        mem_a_addr  = host_a ? idx : rb_ptr;
        mem_a_wdata = host_a ? req_wdata : rb_wdata;
        mem_b_en    = host_b || (rb_rd && !rb_to_b) || (rb_wr && rb_to_b);
        mem_b_we    = host_b ? req_write : (rb_wr && rb_to_b);
        mem_b_addr  = host_b ? idx : rb_ptr;
        mem_b_wdata = host_b ? req_wdata : rb_wdata;
    end

    // Read response tracking: one cycle after the read is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            rsp_q <= req_valid && !req_write;
            sel_q <= sel_b;
        end
    end

    assign rsp_valid = rsp_q;
    assign rsp_rdata = sel_q ? mem_b_rdata : mem_a_rdata;
    assign mode_o    = state;
    assign fault_o   = (state != ST_MIRRORED);

endmodule

// File: rtl/mm_checker.sv
// Property checker for mirror_mem_ctrl, attached by bind.
// Observes ports only; keeps a private copy of the registered enable.
module mm_checker #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_mirror_en,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          rsp_valid,
    input logic [CW-1:0] scrub_err_a,
    input logic [CW-1:0] scrub_err_b,
    input logic          copy_dead_a,
    input logic          copy_dead_b,
    input logic          copy_replaced_b,
    input logic          mem_a_en,
    input logic          mem_a_we,
    input logic [AW-2:0] mem_a_addr,
    input logic [DW-1:0] mem_a_wdata,
    input logic          mem_b_en,
    input logic          mem_b_we,
    input logic [AW-2:0] mem_b_addr,
    input logic [DW-1:0] mem_b_wdata,
    input logic [1:0]    mode_o,
    input logic          fault_o
);

    logic en_q;

    // Local view of when mirroring is in force.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= cfg_mirror_en;
    end

    AST_OFF_ONE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && req_valid) |-> (mem_a_en != mem_b_en) && (mem_b_en == req_addr[AW-1])); // R2

    AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_o == 2'd0 && req_valid && req_write) |->
        (mem_a_en && mem_a_we && mem_b_en && mem_b_we &&
         mem_a_addr == req_addr[AW-2:0] && mem_b_addr == req_addr[AW-2:0])); // R3

    AST_TIE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_o == 2'd0 && req_valid && !req_write && scrub_err_a == scrub_err_b) |->
        (mem_a_en && !mem_a_we && !mem_b_en)); // R4

    AST_FAILOVER_B: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cfg_mirror_en && mode_o == 2'd0 && copy_dead_b && !copy_dead_a) |=>
        (mode_o == 2'd2 && fault_o)); // R5

    AST_DEG_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> !mem_b_en); // R5

    AST_DEG_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> !mem_a_en); // R5

    AST_REBUILD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && cfg_mirror_en && copy_replaced_b) |=> (mode_o == 2'd3)); // R7

    AST_REBUILD_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && req_valid && req_write) |->
        (mem_a_we && mem_b_we && mem_a_wdata == req_wdata && mem_b_wdata == req_wdata)); // R9

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R10

    AST_CLEAR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mirror_en |=> (mode_o == 2'd0 && !fault_o)); // R11

endmodule

bind mirror_mem_ctrl mm_checker #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_mirror_en   (cfg_mirror_en),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .req_wdata       (req_wdata),
    .rsp_valid       (rsp_valid),
    .scrub_err_a     (scrub_err_a),
    .scrub_err_b     (scrub_err_b),
    .copy_dead_a     (copy_dead_a),
    .copy_dead_b     (copy_dead_b),
    .copy_replaced_b (copy_replaced_b),
    .mem_a_en        (mem_a_en),
    .mem_a_we        (mem_a_we),
    .mem_a_addr      (mem_a_addr),
    .mem_a_wdata     (mem_a_wdata),
    .mem_b_en        (mem_b_en),
    .mem_b_we        (mem_b_we),
    .mem_b_addr      (mem_b_addr),
    .mem_b_wdata     (mem_b_wdata),
    .mode_o          (mode_o),
    .fault_o         (fault_o)
);

// File: tb/mirror_mem_ctrl_tb_top.sv
// Bench for mirror_mem_ctrl: seeded random traffic plus directed corners,
// against two behavioural copy RAMs and a logical shadow memory.
module mirror_mem_ctrl_tb_top;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int IW = AW - 1;
    localparam int NW = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_mirror_en = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [CW-1:0] scrub_err_a = '0, scrub_err_b = '0;
    logic          copy_dead_a = 1'b0, copy_dead_b = 1'b0;
    logic          copy_replaced_a = 1'b0, copy_replaced_b = 1'b0;
    logic          mem_a_en, mem_a_we, mem_b_en, mem_b_we;
    logic [IW-1:0] mem_a_addr, mem_b_addr;
    logic [DW-1:0] mem_a_wdata, mem_b_wdata;
    logic [DW-1:0] mem_a_rdata = '0, mem_b_rdata = '0;
    logic [1:0]    mode_o;
    logic          fault_o;

    logic [DW-1:0] mem_a [NW];
    logic [DW-1:0] mem_b [NW];
    logic [DW-1:0] exp_a [NW];
    logic [DW-1:0] exp_b [NW];
    logic [DW-1:0] shadow [NW];
    logic [DW-1:0] snap [NW];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mirror_mem_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (.*);

    // Behavioural copy RAMs with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_a_en) begin
            if (mem_a_we) mem_a[mem_a_addr] <= mem_a_wdata;
            else          mem_a_rdata <= mem_a[mem_a_addr];
        end
        if (mem_b_en) begin
            if (mem_b_we) mem_b[mem_b_addr] <= mem_b_wdata;
            else          mem_b_rdata <= mem_b[mem_b_addr];
        end
    end

    // Expected serving copy under mirrored steering (R4): B only on fewer errors.
    function automatic bit exp_steer_b(input logic [CW-1:0] ea, input logic [CW-1:0] eb);
        return eb < ea;
    endfunction

    // Expected data of a mirrored-mode read given the two copies' contents.
    function automatic logic [DW-1:0] exp_mirror_read(input logic [CW-1:0] ea,
            input logic [CW-1:0] eb, input logic [DW-1:0] da, input logic [DW-1:0] db);
        return exp_steer_b(ea, eb) ? db : da;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        host_op(1'b0, a, '0);
        chk(rsp_valid === 1'b1 && rsp_rdata === exp, tag, {15'd0, rsp_valid, rsp_rdata}, {16'd1, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        case (which)
            0: copy_dead_a = 1'b1;
            1: copy_dead_b = 1'b1;
            2: copy_replaced_a = 1'b1;
            default: copy_replaced_b = 1'b1;
        endcase
        @(negedge clk);
        copy_dead_a = 1'b0; copy_dead_b = 1'b0;
        copy_replaced_a = 1'b0; copy_replaced_b = 1'b0;
    endtask

    // Random host traffic until the rebuild finishes; reads must always see the shadow.
    task automatic rebuild_traffic();
        for (int n = 0; n < 4000 && mode_o != 2'd0; n++) begin
            int r;
            logic [IW-1:0] ix;
            r  = $urandom % 4;
            ix = IW'($urandom);
            scrub_err_a = CW'($urandom);
            scrub_err_b = CW'($urandom);
            if (r < 2) begin
                idle(1);
            end else if (r == 2) begin
                shadow[ix] = DW'($urandom);
                host_op(1'b1, {1'($urandom), ix}, shadow[ix]);
            end else begin
                read_chk({1'($urandom), ix}, shadow[ix], "R8 read during rebuild");
            end
        end
        chk(mode_o == 2'd0 && fault_o == 1'b0, "R7 rebuild completes", {mode_o, fault_o}, 3'b000);
        for (int i = 0; i < NW; i++)
            chk(mem_a[i] === shadow[i] && mem_b[i] === shadow[i], "R7 R9 copies match after rebuild",
                {mem_a[i], mem_b[i]}, {shadow[i], shadow[i]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < NW; i++) begin mem_a[i] = '0; mem_b[i] = '0; end

        // R1: reset state.
        idle(3);
        chk(mode_o == 2'd0 && !fault_o && !rsp_valid, "R1 reset outputs", {mode_o, fault_o, rsp_valid}, 4'd0);
        rst_n = 1'b1;
        idle(1);
        chk(mode_o == 2'd0 && !fault_o && !mem_a_en && !mem_b_en, "R1 idle after reset",
            {mode_o, fault_o, mem_a_en, mem_b_en}, 5'd0);

        // R2: mirroring off, top address bit selects copy.
        for (int i = 0; i < NW; i++) begin
            exp_a[i] = DW'($urandom);
            exp_b[i] = DW'($urandom) ^ 16'h5A5A;
            host_op(1'b1, {1'b0, IW'(i)}, exp_a[i]);
            host_op(1'b1, {1'b1, IW'(i)}, exp_b[i]);
        end
        idle(1);
        for (int i = 0; i < NW; i++)
            chk(mem_a[i] === exp_a[i] && mem_b[i] === exp_b[i], "R1 R2 split writes",
                {mem_a[i], mem_b[i]}, {exp_a[i], exp_b[i]});
        for (int i = 0; i < 6; i++) begin
            logic [IW-1:0] ix;
            ix = IW'($urandom);
            read_chk({1'b0, ix}, exp_a[ix], "R2 read copy A half");
            read_chk({1'b1, ix}, exp_b[ix], "R2 read copy B half");
        end

        // R4: steering by error counts, ties to A, with distinct contents per copy.
        cfg_mirror_en = 1'b1;
        idle(2);
        scrub_err_a = 4'd7; scrub_err_b = 4'd7;
        read_chk({1'b1, 5'd5}, exp_a[5], "R4 tie goes to A");
        scrub_err_a = 4'd3; scrub_err_b = 4'd2;
        read_chk({1'b0, 5'd9}, exp_b[9], "R4 fewer B errors");
        scrub_err_a = 4'd0; scrub_err_b = 4'd15;
        read_chk({1'b1, 5'd31}, exp_a[31], "R4 fewer A errors");
        for (int i = 0; i < 24; i++) begin
            logic [IW-1:0] ix;
            ix = IW'($urandom);
            scrub_err_a = CW'($urandom % 3);
            scrub_err_b = CW'($urandom % 3);
            read_chk({1'($urandom), ix}, exp_mirror_read(scrub_err_a, scrub_err_b, exp_a[ix], exp_b[ix]),
                     "R4 R10 random steering");
        end

        // R3: mirrored writes reach both copies; top bit ignored.
        for (int i = 0; i < NW; i++) begin
            shadow[i] = DW'($urandom);
            host_op(1'b1, {1'($urandom), IW'(i)}, shadow[i]);
        end
        idle(1);
        for (int i = 0; i < NW; i++)
            chk(mem_a[i] === shadow[i] && mem_b[i] === shadow[i], "R3 both copies written",
                {mem_a[i], mem_b[i]}, {shadow[i], shadow[i]});
        scrub_err_a = 4'd9; scrub_err_b = 4'd1;
        read_chk({1'b0, 5'd4}, shadow[4], "R3 read back via B");

        // R5/R6: copy B fails.
        strobe(1);
        chk(mode_o == 2'd2 && fault_o, "R5 failover to A", {mode_o, fault_o}, 3'b101);
        for (int i = 0; i < NW; i++) snap[i] = mem_b[i];
        for (int i = 0; i < 8; i++) begin
            logic [IW-1:0] ix;
            ix = IW'($urandom);
            shadow[ix] = DW'($urandom);
            host_op(1'b1, {1'($urandom), ix}, shadow[ix]);
        end
        scrub_err_a = 4'd15; scrub_err_b = 4'd0;
        for (int i = 0; i < 4; i++) read_chk({1'b0, IW'(i * 7)}, shadow[i * 7], "R5 reads from survivor A");
        begin
            bit same;
            same = 1'b1;
            for (int i = 0; i < NW; i++) if (mem_b[i] !== snap[i]) same = 1'b0;
            chk(same, "R5 failed copy B untouched", {31'd0, same}, 32'd1);
        end
        strobe(2);
        chk(mode_o == 2'd2, "R6 wrong replace strobe ignored", {30'd0, mode_o}, 32'd2);

        // R7/R8/R9: replace B, capture-cycle collision on word 0, then random load.
        for (int i = 0; i < NW; i++) mem_b[i] = ~shadow[i];
        strobe(3);
        chk(mode_o == 2'd3 && fault_o, "R7 rebuild entered", {mode_o, fault_o}, 3'b111);
        idle(1);
        shadow[0] = 16'hC0DE;
        host_op(1'b1, {1'b0, 5'd0}, shadow[0]);
        rebuild_traffic();

        // R5/R7/R9: copy A fails, write-phase collision on word 0.
        strobe(0);
        chk(mode_o == 2'd1 && fault_o, "R5 failover to B", {mode_o, fault_o}, 3'b011);
        scrub_err_a = 4'd0; scrub_err_b = 4'd9;
        read_chk({1'b1, 5'd3}, shadow[3], "R5 reads from survivor B");
        for (int i = 0; i < NW; i++) mem_a[i] = ~shadow[i];
        strobe(2);
        chk(mode_o == 2'd3, "R7 rebuild of A entered", {30'd0, mode_o}, 32'd3);
        idle(2);
        shadow[0] = 16'hBEEF;
        host_op(1'b1, {1'b1, 5'd0}, shadow[0]);
        rebuild_traffic();

        // R11: clearing the enable leaves the degraded mode; dead ignored when off.
        strobe(0);
        chk(mode_o == 2'd1, "R11 precondition degraded", {30'd0, mode_o}, 32'd1);
        cfg_mirror_en = 1'b0;
        idle(1);
        chk(mode_o == 2'd0 && !fault_o, "R11 enable cleared", {mode_o, fault_o}, 3'b000);
        idle(1);
        strobe(1);
        idle(1);
        chk(mode_o == 2'd0 && !fault_o, "R11 dead ignored when off", {mode_o, fault_o}, 3'b000);
        host_op(1'b1, {1'b1, 5'd2}, 16'h1234);
        read_chk({1'b1, 5'd2}, 16'h1234, "R2 split mode after clear");
        chk(mem_a[2] === shadow[2], "R2 copy A untouched by B-half write", {16'd0, mem_a[2]}, {16'd0, shadow[2]});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule